// File: doc/BRIEF.md
# Keypad Edge Interrupt Controller

This block turns up to four key lines into one shared interrupt request for a small microcontroller. Each line has its own enable and its own edge polarity, and a pin only counts when its port direction marks it as an input. The qualified lines are first turned active-high according to polarity and then merged by OR into a single level. Only a rising transition of that merged level sets the pending flag. A consequence follows from this: while any enabled line sits at its active level, transitions on the other lines go unseen. Rewriting the configuration can also move the merged level, and such a change is allowed to register as a request.

Software reaches the block through a byte-wide register bus. It has a configuration byte at address 0x98 and a status byte at address 0x99. The pending flag stays set until software writes a 0 to status bit 0. A separate combinational wake output is driven from the unsynchronized pins, so it can restart a stopped clock.

Top module: `keypad_wake_intc`

## Requirements
- R1: After a synchronous reset the configuration byte reads 0x00 (every line disabled, every polarity falling) and `irq_pending` is 0.
- R2: The configuration byte at address 0x98 is fully writable. Bit 2i enables line i (1 = enabled), and bit 2i+1 selects its polarity (0 = falling, 1 = rising). A read with `bus_rd_en` high returns the byte on `bus_rdata` one clock later.
- R3: An enabled falling-polarity input line that goes from 1 to 0 sets `irq_pending`. If the pin changes between clock edges, the flag is visible after the third rising clock edge that follows.
- R4: An enabled rising-polarity input line that goes from 0 to 1 sets `irq_pending`, with the same latency as R3.
- R5: A line whose enable bit is 0, or whose `pin_is_input` bit is 0, never sets the flag and never drives `key_wake`, whatever its polarity bit is.
- R6: While any enabled line is held at its active level, edges on the other lines do not set the flag. Once that line is released, they do again.
- R7: Writing a byte with bit 0 = 0 to address 0x99 clears `irq_pending` on the next clock. Writing bit 0 = 1 has no effect. If a new request arrives in the same cycle as a clear, the flag stays set.
- R8: `key_wake` is combinational. It is high exactly when some enabled line that is configured as an input is at its active level on the raw, unsynchronized pin.
- R9: A write to the configuration byte that makes the merged level go active (for example, enabling a falling-polarity line whose pin is already low) sets `irq_pending`.
- R10: A read of address 0x99 returns `irq_pending` in bit 0, with zeros in the other bits. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| key_in | input | 4 | Raw key pin levels |
| pin_is_input | input | 4 | Port direction per pin (1 = input) |
| irq_pending | output | 1 | Shared interrupt request flag |
| key_wake | output | 1 | Combinational wake level from raw pins |

## Verification
The assertions take the bus strobes and address as clean synchronous signals. They also assume `pin_is_input` changes only while no edge is in flight, because the direction bits act on the merged level without synchronization. The stimulus drives every input on the falling clock edge and holds the direction bits steady through each scenario. It changes key pins no more than once per several cycles, so the two-stage synchronizer latency stays predictable. Writes and reads are single-cycle strobes with the address held for that cycle.

// File: rtl/kw_pkg.sv
`timescale 1ns/1ps
package kw_pkg;
  typedef struct packed {
    logic pol_rise;
    logic enable;
  } key_cfg_t;

  function automatic logic key_term(input key_cfg_t cfg, input logic is_in, input logic lvl);
    return cfg.enable & is_in & ~(lvl ^ cfg.pol_rise);
  endfunction
endpackage

// File: rtl/kw_sync.sv
`timescale 1ns/1ps
module kw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_async;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/kw_merge.sv
`timescale 1ns/1ps
module kw_merge #(
  parameter int NUM_KEYS = 4
) (
  input  logic [2*NUM_KEYS-1:0] cfg_bits,
  input  logic [NUM_KEYS-1:0]   is_input,
  input  logic [NUM_KEYS-1:0]   lvl,
  output logic                  merged
);
  import kw_pkg::*;
  logic [NUM_KEYS-1:0] term;

  generate
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_term
      key_cfg_t cfg;
      assign cfg     = key_cfg_t'(cfg_bits[2*k +: 2]);
      assign term[k] = key_term(cfg, is_input[k], lvl[k]);
    end
  endgenerate

  assign merged = |term;
endmodule

// File: rtl/kw_req_flag.sv
`timescale 1ns/1ps
module kw_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic merged,
  input  logic clr,
  output logic merged_q,
  output logic pending
);
  logic rise;
  assign rise = merged & ~merged_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      merged_q <= 1'b0;
      pending  <= 1'b0;
    end else begin
      merged_q <= merged;
      if (rise) pending <= 1'b1;
      else if (clr) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/kw_regs.sv
`timescale 1ns/1ps
module kw_regs #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          CTRL_W    = 8,
  parameter logic [7:0]  CFG_ADDR  = 8'h98,
  parameter logic [7:0]  STAT_ADDR = 8'h99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              pending,
  output logic [DATA_W-1:0] rdata,
  output logic [CTRL_W-1:0] cfg_q,
  output logic              clr_pulse
);
  logic hit_cfg, hit_stat;
  logic [DATA_W-1:0] rd_mux;

  assign hit_cfg   = (addr == ADDR_W'(CFG_ADDR));
  assign hit_stat  = (addr == ADDR_W'(STAT_ADDR));
  assign clr_pulse = wr_en & hit_stat & ~wdata[0];

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (wr_en && hit_cfg) cfg_q <= wdata[CTRL_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cfg) rd_mux[CTRL_W-1:0] = cfg_q;
    else if (hit_stat) rd_mux[0] = pending;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/keypad_wake_intc.sv
`timescale 1ns/1ps
module keypad_wake_intc #(
  parameter int         NUM_KEYS    = 4,
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_ADDR    = 8'h98,
  parameter logic [7:0] STAT_ADDR   = 8'h99
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd_en,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_KEYS-1:0] key_in,
  input  logic [NUM_KEYS-1:0] pin_is_input,
  output logic                irq_pending,
  output logic                key_wake
);
  localparam int CTRL_W = 2 * NUM_KEYS;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_KEYS-1:0] key_sync;
  logic                merged_lvl;
  logic                merged_q;
  logic                clr_pulse;

  kw_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
    .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr_en),
    .wdata(bus_wdata), .rd_en(bus_rd_en), .pending(irq_pending),
    .rdata(bus_rdata), .cfg_q(ctrl_q), .clr_pulse(clr_pulse)
  );

  kw_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_async(key_in), .d_sync(key_sync)
  );

  kw_merge #(.NUM_KEYS(NUM_KEYS)) merge_sync_i (
    .cfg_bits(ctrl_q), .is_input(pin_is_input), .lvl(key_sync), .merged(merged_lvl)
  );

  kw_merge #(.NUM_KEYS(NUM_KEYS)) merge_raw_i (
    .cfg_bits(ctrl_q), .is_input(pin_is_input), .lvl(key_in), .merged(key_wake)
  );

  kw_req_flag flag_i (
    .clk(clk), .rst(rst), .merged(merged_lvl), .clr(clr_pulse),
    .merged_q(merged_q), .pending(irq_pending)
  );
endmodule

// File: rtl/kw_checker.sv
`timescale 1ns/1ps
module kw_checker #(
  parameter int         NUM_KEYS  = 4,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] CFG_ADDR  = 8'h98,
  parameter logic [7:0] STAT_ADDR = 8'h99
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr_en,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  bus_rd_en,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  irq_pending,
  input logic                  key_wake,
  input logic [2*NUM_KEYS-1:0] ctrl_q,
  input logic                  merged_lvl,
  input logic                  merged_q
);
  logic [2*NUM_KEYS-1:0] en_mask;
  always_comb begin
    en_mask = '0;
    for (int k = 0; k < NUM_KEYS; k++) en_mask[2*k] = 1'b1;
  end

  logic clr_wr;
  assign clr_wr = bus_wr_en && (bus_addr == ADDR_W'(STAT_ADDR)) && !bus_wdata[0];

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!irq_pending && ctrl_q == '0));

  p_cfg_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == ADDR_W'(CFG_ADDR)) |=> (bus_rdata[2*NUM_KEYS-1:0] == $past(ctrl_q)));

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (merged_lvl && !merged_q) |=> irq_pending);

  p_no_spurious_set_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> ($past(merged_lvl) && !$past(merged_q)));

  p_disabled_silent_r5: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q & en_mask) == '0) |-> (!key_wake && !merged_lvl));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && !clr_wr) |=> irq_pending);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !(merged_lvl && !merged_q)) |=> !irq_pending);

  p_status_read_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == ADDR_W'(STAT_ADDR)) |=> (bus_rdata == DATA_W'($past(irq_pending))));
endmodule

bind keypad_wake_intc kw_checker #(
  .NUM_KEYS(NUM_KEYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
  .irq_pending(irq_pending), .key_wake(key_wake), .ctrl_q(ctrl_q),
  .merged_lvl(merged_lvl), .merged_q(merged_q)
);

// File: tb/keypad_wake_intc_tb_top.sv
`timescale 1ns/1ps
module keypad_wake_intc_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd_en = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] key_in = 4'hF;
  logic [3:0] pin_is_input = 4'hF;
  logic       irq_pending;
  logic       key_wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keypad_wake_intc dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .key_in(key_in), .pin_is_input(pin_is_input),
    .irq_pending(irq_pending), .key_wake(key_wake)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  function automatic bit any_active(input logic [7:0] cfg, input logic [3:0] lv, input logic [3:0] dir);
    bit hit = 0;
    for (int k = 0; k < 4; k++)
      if (cfg[2*k] == 1'b1 && dir[k] == 1'b1 && lv[k] == cfg[2*k+1]) hit = 1;
    return hit;
  endfunction

  logic [7:0] m_ctrl = 0, m_rdata = 0;
  logic [3:0] m_s1 = 0, m_s2 = 0;
  bit m_pend = 0, m_prev = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_rdata = 0; m_s1 = 0; m_s2 = 0; m_pend = 0; m_prev = 0;
    end else begin
      bit now_act, clr;
      now_act = any_active(m_ctrl, m_s2, pin_is_input);
      clr = bus_wr_en && bus_addr == 8'h99 && !bus_wdata[0];
      if (bus_rd_en)
        m_rdata = (bus_addr == 8'h98) ? m_ctrl : (bus_addr == 8'h99) ? {7'b0, m_pend} : 8'h00;
      m_pend = (now_act && !m_prev) || (m_pend && !clr);
      m_prev = now_act;
      m_s2 = m_s1;
      m_s1 = key_in;
      if (bus_wr_en && bus_addr == 8'h98) m_ctrl = bus_wdata;
    end
    #2;
    if (!rst && !done) begin
      chk("R3 model irq", {7'b0, irq_pending}, {7'b0, m_pend});
      chk("R8 model wake", {7'b0, key_wake}, {7'b0, any_active(m_ctrl, key_in, pin_is_input)});
      chk("R2 model rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr_en = 1;
    @(negedge clk); bus_wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd_en = 1;
    @(negedge clk); bus_rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_key(input int k, input logic v);
    @(negedge clk); key_in[k] = v;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R1 irq after reset", {7'b0, irq_pending}, 8'h00);
    rd(8'h98);
    chk("R1 cfg after reset", bus_rdata, 8'h00);

    wr(8'h98, 8'h01);
    rd(8'h98);
    chk("R2 cfg readback", bus_rdata, 8'h01);

    // R3 falling edge on line 0, wake is immediate
    @(negedge clk); key_in[0] = 0;
    #1 chk("R8 wake raw", {7'b0, key_wake}, 8'h01);
    @(posedge clk); @(posedge clk); #1;
    chk("R3 not yet", {7'b0, irq_pending}, 8'h00);
    @(posedge clk); #1;
    chk("R3 falling set", {7'b0, irq_pending}, 8'h01);
    rd(8'h99);
    chk("R10 status read", bus_rdata, 8'h01);
    wr(8'h99, 8'h00);
    chk("R7 clear", {7'b0, irq_pending}, 8'h00);

    // R6 masking: line 0 held low, line 1 pulsed
    wr(8'h98, 8'h05);
    idle(3);
    set_key(1, 0); idle(3); set_key(1, 1); idle(4);
    chk("R6 masked", {7'b0, irq_pending}, 8'h00);
    set_key(0, 1); idle(4);
    set_key(1, 0); idle(4);
    chk("R6 unmasked", {7'b0, irq_pending}, 8'h01);
    wr(8'h99, 8'h01);
    chk("R7 write one ignored", {7'b0, irq_pending}, 8'h01);
    set_key(1, 1); idle(3);
    wr(8'h99, 8'h00);

    // R9 enabling rising polarity on a high pin raises a request
    wr(8'h98, 8'h0C);
    idle(1);
    chk("R9 rewrite request", {7'b0, irq_pending}, 8'h01);
    wr(8'h99, 8'h00);
    chk("R9 cleared", {7'b0, irq_pending}, 8'h00);

    // R4 rising edge
    set_key(1, 0); idle(4);
    chk("R4 fall ignored", {7'b0, irq_pending}, 8'h00);
    set_key(1, 1); idle(4);
    chk("R4 rising set", {7'b0, irq_pending}, 8'h01);

    // R7 set wins over simultaneous clear
    set_key(1, 0); idle(4);
    @(negedge clk); key_in[1] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 8'h99; bus_wdata = 8'h00; bus_wr_en = 1;
    @(negedge clk); bus_wr_en = 0;
    chk("R7 set beats clear", {7'b0, irq_pending}, 8'h01);
    wr(8'h99, 8'h00);

    // R5 disabled line with rising polarity bit
    wr(8'h98, 8'h02);
    set_key(0, 0); idle(4); set_key(0, 1); idle(4);
    chk("R5 disabled", {7'b0, irq_pending}, 8'h00);
    chk("R5 wake disabled", {7'b0, key_wake}, 8'h00);
    // R5 pin configured as output
    @(negedge clk); pin_is_input = 4'hE;
    wr(8'h98, 8'h01);
    set_key(0, 0); idle(4);
    chk("R5 output pin", {7'b0, irq_pending}, 8'h00);
    chk("R5 output pin wake", {7'b0, key_wake}, 8'h00);
    rd(8'h42);
    chk("R10 unmapped read", bus_rdata, 8'h00);

    done = 1;
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule